// File: doc/BRIEF.md
# Single-Wire Debug Bit Responder

This block is the target end of a single-wire, open-drain debug link. It returns one byte to the host, one bit per bit slot. The host opens every slot by pulling the shared line low. The block never opens a slot itself. It sees the host edge through a synchronizer running on the local debug clock and then ends the slot.

- To send a 0, it holds the line low for a fixed number of cycles, then drives one short active-high speed-up pulse, then releases the line.
- To send a 1, it leaves the line released. The host's own brief low pulse and the pull-up form the bit.

A parent loads the byte through a valid/ready handshake. Bits leave most significant first. A one-cycle done flag marks the end of the eighth slot, and the block then returns to idle, ready for the next byte.

Top module: `dbgline_tx`

## Requirements
- R1: After reset both drive enables are low, `load_ready_o` is high and `done_o` is low.
- R2: A byte is accepted on a rising edge where `load_valid_i` and `load_ready_o` are both high. From the next cycle `load_ready_o` stays low until that byte has been fully sent.
- R3: With a byte pending, a falling edge on `line_i` opens a slot. The first rising clock edge that samples the line low is counted as edge one. The block acts on edge SYNC_STAGES+1, which is edge 3 by default.
- R4: For a 0 bit, `drive_lo_o` is high for exactly LOW_CYCLES consecutive cycles (13 by default). This keeps the line low past the host's sample point about 10 cycles into the slot.
- R5: Right after the low period, `drive_hi_o` is high for exactly PULSE_CYCLES cycles (1 by default). Both enables then go low.
- R6: For a 1 bit, neither enable is asserted during the slot. The slot lasts LOW_CYCLES+PULSE_CYCLES cycles.
- R7: Bits are sent from bit 7 down to bit 0, one per host-opened slot.
- R8: `done_o` is high for exactly one cycle, in the cycle right after the eighth slot ends. In that same cycle `load_ready_o` is high again.
- R9: `drive_lo_o` and `drive_hi_o` are never high together. Both are low whenever the block is idle.
- R10: A falling edge that arrives during an open slot, or while no byte is pending, starts nothing. It neither adds a slot nor changes the order of the bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local debug clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Level of the shared debug line (asynchronous) |
| drive_lo_o | output | 1 | Enable for the pull-low driver |
| drive_hi_o | output | 1 | Enable for the speed-up high driver |
| load_valid_i | input | 1 | Byte offered for transmission |
| load_ready_o | output | 1 | Block is idle and will take a byte |
| load_data_i | input | DATA_W | Byte to transmit |
| done_o | output | 1 | One-cycle pulse after the last slot |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 13-cycle low period and a one-cycle speed-up pulse. It derives every expected cycle offset from those values. With these defaults the host sample point at cycle 10 falls inside the low window, so the bench can check both that a 0 is still visible to the host and that the line is released before the next slot may open. Mixed byte patterns, together with stray host pulses inside a 1 slot and while idle, exercise the ignore rules.

// File: rtl/dbgline_pkg.sv
package dbgline_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_LOW   = 3'd2,
    ST_PULSE = 3'd3,
    ST_SKIP  = 3'd4
  } slot_state_e;
endpackage

// File: rtl/dbgline_sync.sv
module dbgline_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/dbgline_shift.sv
module dbgline_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  output logic              cur_bit,
  output logic              last_bit
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load_en) begin
      sh_d  = load_data;
      cnt_d = '0;
    end else if (shift_en) begin
      sh_d  = {sh_q[DATA_W-2:0], 1'b0};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_en || shift_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign cur_bit  = sh_q[DATA_W-1];
  assign last_bit = (cnt_q == CW'(DATA_W-1));
endmodule

// File: rtl/dbgline_tx.sv
module dbgline_tx
  import dbgline_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_CYCLES  = 13,
  parameter int PULSE_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic              drive_lo_o,
  output logic              drive_hi_o,
  input  logic              load_valid_i,
  output logic              load_ready_o,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              done_o
);
  localparam int SLOT_CYCLES = LOW_CYCLES + PULSE_CYCLES;
  localparam int TW          = $clog2(SLOT_CYCLES + 1);

  slot_state_e   state_q, state_d;
  logic [TW-1:0] timer_q, timer_d;
  logic          done_q, done_d;
  logic          fall, cur_bit, last_bit, load_en, shift_en;

  dbgline_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .fall_o (fall)
  );

  dbgline_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_data (load_data_i),
    .shift_en  (shift_en),
    .cur_bit   (cur_bit),
    .last_bit  (last_bit)
  );

  always_comb begin
    state_d  = state_q;
    timer_d  = timer_q;
    done_d   = 1'b0;
    load_en  = 1'b0;
    shift_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (load_valid_i) begin
          load_en = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (fall) begin
          if (!cur_bit) begin
            state_d = ST_LOW;
            timer_d = TW'(LOW_CYCLES - 1);
          end else begin
            state_d = ST_SKIP;
            timer_d = TW'(SLOT_CYCLES - 1);
          end
        end
      end
      ST_LOW: begin
        if (timer_q == '0) begin
          state_d = ST_PULSE;
          timer_d = TW'(PULSE_CYCLES - 1);
        end else begin
          timer_d = timer_q - 1'b1;
        end
      end
      ST_PULSE, ST_SKIP: begin
        if (timer_q == '0) begin
          shift_en = 1'b1;
          if (last_bit) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_WAIT;
          end
        end else begin
          timer_d = timer_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      timer_q <= timer_d;
      done_q  <= done_d;
    end
  end

  assign drive_lo_o   = (state_q == ST_LOW);
  assign drive_hi_o   = (state_q == ST_PULSE);
  assign load_ready_o = (state_q == ST_IDLE);
  assign done_o       = done_q;
endmodule

// File: rtl/dbgline_tx_chk.sv
module dbgline_tx_chk #(
  parameter int LOW_CYCLES = 13
) (
  input logic clk,
  input logic rst_n,
  input logic drive_lo_o,
  input logic drive_hi_o,
  input logic load_valid_i,
  input logic load_ready_o,
  input logic done_o
);
  localparam int RW = $clog2(LOW_CYCLES + 2);
  logic [RW-1:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lo_run <= '0;
    else if (drive_lo_o)
      lo_run <= (lo_run == RW'(LOW_CYCLES + 1)) ? lo_run : lo_run + 1'b1;
    else
      lo_run <= '0;
  end

  // R9
  no_both_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_lo_o && drive_hi_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ready_o |-> (!drive_lo_o && !drive_hi_o));

  // R4
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_lo_o) |-> (lo_run == RW'(LOW_CYCLES)));

  // R4
  low_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run <= RW'(LOW_CYCLES));

  // R5
  pulse_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_lo_o) |-> drive_hi_o);

  // R5
  release_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_hi_o |=> !drive_lo_o);

  // R8
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> load_ready_o);

  // R2
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid_i && load_ready_o) |=> !load_ready_o);
endmodule

bind dbgline_tx dbgline_tx_chk #(.LOW_CYCLES(LOW_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .drive_lo_o   (drive_lo_o),
  .drive_hi_o   (drive_hi_o),
  .load_valid_i (load_valid_i),
  .load_ready_o (load_ready_o),
  .done_o       (done_o)
);

// File: tb/dbgline_tx_test.sv
module dbgline_tx_test;
  localparam int DATA_W = 8;
  localparam int SYNC   = 2;
  localparam int LOWC   = 13;
  localparam int PULSEC = 1;
  localparam int SLOT   = LOWC + PULSEC;
  localparam int WIN    = SLOT + 10;

  logic clk = 1'b0;
  logic rst_n;
  logic host_low;
  logic line;
  logic drive_lo, drive_hi, load_valid, load_ready, done;
  logic [DATA_W-1:0] load_data;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign line = (drive_lo || host_low) ? 1'b0 : 1'b1;

  dbgline_tx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC), .LOW_CYCLES(LOWC),
               .PULSE_CYCLES(PULSEC)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line),
    .drive_lo_o   (drive_lo),
    .drive_hi_o   (drive_hi),
    .load_valid_i (load_valid),
    .load_ready_o (load_ready),
    .load_data_i  (load_data),
    .done_o       (done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One host-opened slot; optional stray host pulse at cycle stray_at (0 = none)
  task automatic run_slot(input bit bitval, input bit is_last, input int stray_at);
    int lo_cnt = 0, hi_cnt = 0, first_lo = 0, first_hi = 0, done_cnt = 0, done_at = 0;
    int both = 0, seen_bit = 1;
    @(negedge clk);
    host_low = 1'b1;
    for (int n = 1; n <= WIN; n++) begin
      @(negedge clk);
      if (n == 4) host_low = 1'b0;
      if (stray_at != 0 && n == stray_at) host_low = 1'b1;
      if (stray_at != 0 && n == stray_at + 2) host_low = 1'b0;
      if (drive_lo) begin lo_cnt++; if (first_lo == 0) first_lo = n; end
      if (drive_hi) begin hi_cnt++; if (first_hi == 0) first_hi = n; end
      if (drive_lo && drive_hi) both++;
      if (done) begin done_cnt++; done_at = n; end
      if (n == 10) seen_bit = line;
    end
    if (!bitval) begin
      check(first_lo == SYNC + 1, "R3 drive-low start cycle", first_lo, SYNC + 1);
      check(lo_cnt == LOWC, "R4 low length", lo_cnt, LOWC);
      check(seen_bit == 0, "R4 line low at host sample", seen_bit, 0);
      check(first_hi == SYNC + 1 + LOWC, "R5 pulse position", first_hi, SYNC + 1 + LOWC);
      check(hi_cnt == PULSEC, "R5 pulse length", hi_cnt, PULSEC);
    end else begin
      check(lo_cnt == 0 && hi_cnt == 0, "R6 no drive for 1 bit", lo_cnt + hi_cnt, 0);
    end
    check(both == 0, "R9 enables exclusive", both, 0);
    check(seen_bit == int'(bitval), "R7 bit value at sample", seen_bit, int'(bitval));
    if (is_last) begin
      check(done_cnt == 1 && done_at == SYNC + 1 + SLOT,
            "R8 done pulse", done_at, SYNC + 1 + SLOT);
      check(load_ready == 1'b1, "R8 ready after byte", load_ready, 1);
    end else begin
      check(done_cnt == 0, "R8 no early done", done_cnt, 0);
      check(load_ready == 1'b0, "R2 ready low mid-byte", load_ready, 0);
    end
  endtask

  task automatic load_byte(input logic [DATA_W-1:0] b);
    @(negedge clk);
    check(load_ready == 1'b1, "R2 ready before load", load_ready, 1);
    load_valid = 1'b1;
    load_data  = b;
    @(negedge clk);
    load_valid = 1'b0;
    check(load_ready == 1'b0, "R2 ready drops after accept", load_ready, 0);
  endtask

  task automatic send_byte(input logic [DATA_W-1:0] b, input int stray_bit);
    load_byte(b);
    for (int i = DATA_W - 1; i >= 0; i--)
      run_slot(b[i], i == 0, (i == stray_bit) ? 7 : 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(drive_lo == 0 && drive_hi == 0, "R1 enables low", drive_lo + drive_hi, 0);
    check(load_ready == 1'b1, "R1 ready high", load_ready, 1);
    check(done == 1'b0, "R1 done low", done, 0);
  endtask

  task automatic test_idle_edge();
    int drv = 0;
    @(negedge clk);
    host_low = 1'b1;
    for (int n = 1; n <= WIN; n++) begin
      @(negedge clk);
      if (n == 4) host_low = 1'b0;
      if (drive_lo || drive_hi || done) drv++;
    end
    check(drv == 0, "R10 idle edge ignored", drv, 0);
    check(load_ready == 1'b1, "R10 ready kept when idle", load_ready, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    host_low   = 1'b0;
    load_valid = 1'b0;
    load_data  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_idle_edge();
    send_byte(8'hA5, -1);   // R7 mixed pattern, MSB first
    send_byte(8'h00, -1);   // R4 all zero slots
    send_byte(8'hFF, -1);   // R6 all one slots
    send_byte(8'h6C, 6);    // R10 stray pulse inside a 1 slot (bit 6)
    test_idle_edge();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule